// File: doc/BRIEF.md
# Accuracy-Configurable Timing-Error Recovery Controller

This controller sits next to one floating-point pipeline that yields 32-bit single-precision results. Circuit-level error sensors raise one timing-error flag per result bit. For every completed pass of an operation, the controller looks at those flags and chooses one of two outcomes. It either asks for the operation to be replayed with the same operands and at the same clock frequency, or it declares the operation finished. Each issued operation carries its own mode bit. In accurate mode, a flag on any bit forces a replay. In approximate mode, the controller ignores flags on the lowest N fraction bits. The sign bit and the exponent bits are always checked.

Software sets N through a register write port. Values larger than the 23-bit fraction width are clamped to 23. The controller reports tolerated errors on a status strobe and counts them in a saturating counter; a tolerated error never stalls the pipeline. A limit on consecutive replays protects against an operation that never comes out clean. When that limit is passed, a sticky fault flag is set.

Top module: `ter_ctrl`

## Requirements
- R1: After reset, replay_req, op_done, masked_err and fault are 0, masked_cnt is 0 and N is 0.
- R2: A pass (op_valid=1) with op_approx=0 and any bit of err_flags set gives replay_req=1 and op_done=0 in the following cycle.
- R3: A pass with op_approx=1 in which flags appear only on bits below N (bits 0 to N-1 of the fraction field 22:0) gives op_done=1, replay_req=0 and masked_err=1 in the following cycle.
- R4: A flag on the sign bit (31) or on an exponent bit (30:23) always gives a replay or a fault, whatever the mode and N. A flag on a fraction bit at or above N does the same.
- R5: A cfg_we cycle loads N from cfg_n. Values above 23 load as 23.
- R6: With N=0, approximate mode behaves exactly like accurate mode.
- R7: A pass with no unmasked flag gives op_done=1 for exactly one cycle, in the cycle after the pass. replay_req and op_done are never 1 together, and neither is 1 unless a pass occurred in the previous cycle.
- R8: The controller counts replays for the current operation. After MAX_REPLAY replays, the next pass with an unmasked error sets fault and gives neither replay_req nor op_done. The replay count clears on op_done or on a fault.
- R9: Once fault is set, it stays set until reset. Later operations are still handled normally.
- R10: masked_err is 1 in the cycle after any pass in which approximate mode hid at least one flag. Each such pass adds one to masked_cnt, which stops at its maximum value.
- R11: Passes of the two modes may follow each other on consecutive cycles. Each pass is judged only by its own mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the tolerance register N |
| cfg_n | input | 5 | Value written to N (clamped to 23) |
| op_valid | input | 1 | A pass of an operation completes this cycle |
| op_approx | input | 1 | Mode of this pass: 1 approximate, 0 accurate |
| err_flags | input | 32 | Per-bit timing-error flags for the result |
| replay_req | output | 1 | Request to re-issue the same operation |
| op_done | output | 1 | Operation finished without unmasked error |
| masked_err | output | 1 | The last pass had at least one tolerated flag |
| fault | output | 1 | Sticky: replay limit exceeded |
| masked_cnt | output | CNT_W | Saturating count of passes with tolerated flags |

## Verification
The hardest state to reach is the boundary between tolerated and protected flags, and especially the boundary that the clamp creates when software writes an N above 23. That boundary only shows up when a single flag sits exactly at bit N-1 or at bit N. The bench therefore writes every 5-bit value of N, including the out-of-range ones. For each value it walks a single flag across all 32 bit positions in both modes. Any pass that is replayed is followed by a clean pass, so that the replay count is back at zero before the next vector. The fault flag needs several errored passes of one operation in a row. A dedicated sequence therefore holds a sign-bit flag for MAX_REPLAY+1 passes, then checks that the flag stays set while a clean operation completes.

// File: rtl/ter_pkg.sv
package ter_pkg;
  localparam int WORD_W = 32;
  localparam int FRAC_W = 23;
  localparam int NW     = $clog2(FRAC_W + 1);

  // Clamp a requested tolerance width to the fraction width.
  function automatic logic [NW-1:0] clamp_n(input logic [NW-1:0] n);
    if (int'(n) > FRAC_W) return NW'(FRAC_W);
    return n;
  endfunction

  // Bits whose flags are tolerated in approximate mode: fraction bits below n.
  function automatic logic [WORD_W-1:0] tol_mask(input logic [NW-1:0] n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < FRAC_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction
endpackage

// File: rtl/ter_cfg_reg.sv
module ter_cfg_reg
  import ter_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NW-1:0] wdata,
  output logic [NW-1:0] n_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  n_q <= '0;
    else if (we) n_q <= clamp_n(wdata);
  end
endmodule

// File: rtl/ter_err_split.sv
module ter_err_split
  import ter_pkg::*;
(
  input  logic [WORD_W-1:0] flags,
  input  logic              approx,
  input  logic [NW-1:0]     n,
  output logic              hard_err,
  output logic              soft_err
);
  logic [WORD_W-1:0] tol;
  always_comb begin
    tol      = approx ? tol_mask(n) : '0;
    hard_err = |(flags & ~tol);
    soft_err = |(flags & tol);
  end
endmodule

// File: rtl/ter_retry_ctl.sv
module ter_retry_ctl #(
  parameter int MAX_REPLAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_valid,
  input  logic hard_err,
  output logic replay_req,
  output logic op_done,
  output logic fault
);
  localparam int RW = $clog2(MAX_REPLAY + 1);
  logic [RW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries_q    <= '0;
      replay_req <= 1'b0;
      op_done    <= 1'b0;
      fault      <= 1'b0;
    end else begin
      replay_req <= 1'b0;
      op_done    <= 1'b0;
      if (pass_valid) begin
        if (!hard_err) begin
          op_done <= 1'b1;
          tries_q <= '0;
        end else if (tries_q == RW'(MAX_REPLAY)) begin
          fault   <= 1'b1;
          tries_q <= '0;
        end else begin
          replay_req <= 1'b1;
          tries_q    <= tries_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ter_sat_cnt.sv
module ter_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (inc && ~&cnt)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ter_ctrl.sv
module ter_ctrl
  import ter_pkg::*;
#(
  parameter int MAX_REPLAY = 3,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_n,
  input  logic             op_valid,
  input  logic             op_approx,
  input  logic [31:0]      err_flags,
  output logic             replay_req,
  output logic             op_done,
  output logic             masked_err,
  output logic             fault,
  output logic [CNT_W-1:0] masked_cnt
);
  logic [NW-1:0] n_eff;
  logic          hard_err, soft_err, soft_hit;

  ter_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_n), .n_q(n_eff)
  );

  ter_err_split u_split (
    .flags(err_flags), .approx(op_approx), .n(n_eff),
    .hard_err(hard_err), .soft_err(soft_err)
  );

  assign soft_hit = op_valid & soft_err;

  ter_retry_ctl #(.MAX_REPLAY(MAX_REPLAY)) u_retry (
    .clk(clk), .rst_n(rst_n), .pass_valid(op_valid), .hard_err(hard_err),
    .replay_req(replay_req), .op_done(op_done), .fault(fault)
  );

  ter_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(soft_hit), .cnt(masked_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) masked_err <= 1'b0;
    else        masked_err <= soft_hit;
  end
endmodule

// File: rtl/ter_ctrl_chk.sv
module ter_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_approx,
  input logic [31:0]      err_flags,
  input logic             replay_req,
  input logic             op_done,
  input logic             fault,
  input logic [CNT_W-1:0] masked_cnt,
  input logic [4:0]       n_eff
);
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(replay_req && op_done));

  assert_done_needs_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done || replay_req) |-> $past(op_valid));

  assert_accurate_replays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_approx && (|err_flags)) |=> !op_done);

  assert_sign_exp_protected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (|err_flags[31:23])) |=> !op_done);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  assert_cnt_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> masked_cnt >= $past(masked_cnt));

  assert_n_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    n_eff <= 5'd23);
endmodule

bind ter_ctrl ter_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_approx(op_approx),
  .err_flags(err_flags), .replay_req(replay_req), .op_done(op_done),
  .fault(fault), .masked_cnt(masked_cnt), .n_eff(n_eff)
);

// File: tb/tb_ter_ctrl.sv
module tb_ter_ctrl;
  localparam int MAX_REPLAY = 3;
  localparam int CNT_W      = 8;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [4:0]       cfg_n = '0;
  logic             op_valid = 1'b0;
  logic             op_approx = 1'b0;
  logic [31:0]      err_flags = '0;
  logic             replay_req, op_done, masked_err, fault;
  logic [CNT_W-1:0] masked_cnt;

  int vectors = 0;
  int fails   = 0;
  int cnt_model = 0;

  always #2.5 clk = ~clk;

  ter_ctrl #(.MAX_REPLAY(MAX_REPLAY), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_n(cfg_n),
    .op_valid(op_valid), .op_approx(op_approx), .err_flags(err_flags),
    .replay_req(replay_req), .op_done(op_done), .masked_err(masked_err),
    .fault(fault), .masked_cnt(masked_cnt)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic write_n(input logic [4:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_n = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Drive one pass; outputs are sampled 1 time unit after the capturing edge.
  task automatic pass(input logic approx, input logic [31:0] flags);
    @(negedge clk);
    op_valid = 1'b1; op_approx = approx; err_flags = flags;
    @(posedge clk); #1;
    op_valid = 1'b0; err_flags = '0;
  endtask

  task automatic expect_out(input string tag, input bit e_rep, input bit e_done,
                            input bit e_mask, input bit e_fault);
    chk(tag, "replay_req", 32'(replay_req), 32'(e_rep));
    chk(tag, "op_done",    32'(op_done),    32'(e_done));
    chk(tag, "masked_err", 32'(masked_err), 32'(e_mask));
    chk(tag, "fault",      32'(fault),      32'(e_fault));
    chk(tag, "masked_cnt", 32'(masked_cnt), 32'(cnt_model));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    expect_out("R1", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: N resets to 0, so an approximate low-bit flag still replays
    pass(1'b1, 32'h1);
    expect_out("R1", 1, 0, 0, 0);
    pass(1'b0, 32'h0);
    expect_out("R1", 0, 1, 0, 0);

    // Sweep every N value, both modes, every single-flag position
    for (int nw = 0; nw < 32; nw++) begin
      int neff;
      neff = (nw > 23) ? 23 : nw;
      write_n(5'(nw));
      for (int md = 0; md < 2; md++) begin
        for (int b = 0; b < 32; b++) begin
          bit hard;
          string tag;
          hard = (md == 0) || (b >= neff);
          if (b >= 23)       tag = "R4";
          else if (md == 0)  tag = "R2";
          else if (nw > 23)  tag = "R5";
          else if (nw == 0)  tag = "R6";
          else               tag = "R3";
          pass(md[0], 32'(1) << b);
          if (!hard && cnt_model < CNT_MAX) cnt_model++;
          expect_out(tag, hard, !hard, !hard, 0);
          if (hard) begin
            pass(md[0], 32'h0);
            expect_out("R7", 0, 1, 0, 0);
          end
        end
      end
    end
    // R10: count saturated after many tolerated passes
    chk("R10", "masked_cnt saturated", 32'(masked_cnt), 32'(CNT_MAX));

    // R11: back-to-back interleaving of modes, N=10
    write_n(5'd10);
    pass(1'b1, 32'h0000_0020);
    expect_out("R11", 0, 1, 1, 0);
    pass(1'b0, 32'h0000_0020);
    expect_out("R11", 1, 0, 0, 0);
    pass(1'b1, 32'h0000_0020);
    expect_out("R11", 0, 1, 1, 0);
    // R10/R4: mixed masked and protected flags in one pass
    pass(1'b1, 32'h0000_0401);
    expect_out("R10", 1, 0, 1, 0);
    pass(1'b1, 32'h0);
    expect_out("R7", 0, 1, 0, 0);

    // R8: replay limit then fault
    for (int k = 0; k < MAX_REPLAY; k++) begin
      pass(1'b0, 32'h8000_0000);
      expect_out("R8", 1, 0, 0, 0);
    end
    pass(1'b0, 32'h8000_0000);
    expect_out("R8", 0, 0, 0, 1);
    // R9: fault sticky, next operation handled normally
    pass(1'b0, 32'h0);
    expect_out("R9", 0, 1, 0, 1);
    pass(1'b0, 32'h0000_0100);
    expect_out("R9", 1, 0, 0, 1);
    pass(1'b0, 32'h0);
    expect_out("R9", 0, 1, 0, 1);
    repeat (2) @(posedge clk);
    #1;
    expect_out("R9", 0, 0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule